// File: doc/BRIEF.md
# Colour-Grading Table Indirect Access Port

This block gives a host a two-register window onto six small colour-grading lookup tables held in on-chip memory. The host first writes a control word that picks one table, a starting slot and an access mode. It then reads or writes table contents through a single 16-bit data register. In normal mode every data access reaches the same slot. In bulk mode the slot index steps forward by one after each data access, so a host can stream a whole table through one address without rewriting the control word.

Each table also has its own read port for the pixel pipeline. That port returns the stored value, sign- or zero-extended to 16 bits, one cycle after the address is presented. The tables differ in stored width and signedness. Values are cut down to the table's width when written and widened again when read. The two table codes that have no table behind them accept no writes and read back as zero.

Top module: `cgl_port`

## Requirements
- R1: After reset the control state selects table 0, slot 0, normal mode, and `bus_rvalid` is low.
- R2: A write to word address 0x2E loads the control word: bits 9:7 are the table code, bits 6:1 the slot index, bit 0 the mode (0 normal, 1 bulk). Bits 15:10 are ignored.
- R3: A write to word address 0x2F stores `bus_wdata` into the selected slot of the selected table. The new value appears on that table's pixel read port one cycle after the slot address is presented there.
- R4: A read strobe on 0x2F (with `bus_wr` low) gives `bus_rvalid` high and the slot contents on `bus_rdata` in the following cycle. In every other case `bus_rvalid` is low in the following cycle.
- R5: In normal mode, repeated data accesses all reach the same slot. The index changes only when the control word is rewritten.
- R6: In bulk mode the index increases by one after each data read or write. A read returns the slot addressed before the increment.
- R7: In bulk mode the index wraps from 63 to 0.
- R8: Table code 0 (hue vs hue) keeps 14 bits and reads back sign-extended from bit 13.
- R9: Table codes 1, 2 and 3 (hue vs saturation, lightness vs saturation, saturation vs saturation) keep 12 bits and read back zero-extended.
- R10: Table codes 4 and 5 (lightness vs lightness, hue vs lightness) keep 13 bits and read back sign-extended from bit 12.
- R11: With table code 6 or 7 selected, data writes change no table, data reads return zero with `bus_rvalid` high, and the index does not move.
- R12: Writes to any other word address leave the tables and the control state unchanged. Reads of any address other than 0x2F leave `bus_rvalid` low.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| pix_addr | input | 36 | Pixel read slot, 6 bits per table, table 0 in the low bits |
| pix_rdata | output | 96 | Pixel read value, 16 bits per table, extended |

## Verification
The bench checks that each table code reaches its own memory by writing one slot, and that a wrong mapping shows up as data in the wrong table. It checks sign extension at bit 13, bit 12 and none, using values whose top stored bit is set. A design that widened a table wrongly would return the raw value or fill the top bits with ones. It streams data in bulk mode across the 63-to-0 boundary and checks that a bulk read returns the slot before the step. An index that stepped early, or that stopped at 63, gives shifted or missing data. Writes with reserved codes must leave every table untouched and must read back as zero, so a design that aliased code 6 onto a real table fails.

// File: rtl/cgl_pkg.sv
package cgl_pkg;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 6;
  localparam int TSEL_W  = 3;
  localparam int NUM_TBL = 6;
  localparam int ADDR_W  = 8;

  // stored width per table code
  function automatic int tbl_w(input int t);
    case (t)
      0:       return 14;
      1, 2, 3: return 12;
      default: return 13;
    endcase
  endfunction

  // signed storage per table code
  function automatic bit tbl_sgn(input int t);
    return (t == 0) || (t >= 4);
  endfunction
endpackage

// File: rtl/cgl_sel.sv
module cgl_sel #(
  parameter int IDX_W   = 6,
  parameter int TSEL_W  = 3,
  parameter int NUM_TBL = 6,
  localparam int CW     = 1 + IDX_W + TSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [CW-1:0]     sel_wdata,
  input  logic              data_acc,
  output logic [TSEL_W-1:0] tbl,
  output logic [IDX_W-1:0]  idx,
  output logic              bulk,
  output logic              tbl_ok
);
  assign tbl_ok = (32'(tbl) < NUM_TBL);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl  <= '0;
      idx  <= '0;
      bulk <= 1'b0;
    end else if (sel_we) begin
      bulk <= sel_wdata[0];
      idx  <= sel_wdata[1 +: IDX_W];
      tbl  <= sel_wdata[1 + IDX_W +: TSEL_W];
    end else if (data_acc && bulk && tbl_ok) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/cgl_tbl.sv
module cgl_tbl #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int W      = 12,
  parameter bit SGN    = 1'b0,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  a_addr,
  input  logic [W-1:0]      wdata,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_addr,
  output logic [DATA_W-1:0] b_data
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] qa, qb;

  always_ff @(posedge clk) begin
    if (we) mem[a_addr] <= wdata;
    if (re) qa <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    qb <= mem[b_addr];
  end

  generate
    if (SGN) begin : g_sx
      assign a_data = {{(DATA_W-W){qa[W-1]}}, qa};
      assign b_data = {{(DATA_W-W){qb[W-1]}}, qb};
    end else begin : g_zx
      assign a_data = {{(DATA_W-W){1'b0}}, qa};
      assign b_data = {{(DATA_W-W){1'b0}}, qb};
    end
  endgenerate
endmodule

// File: rtl/cgl_port.sv
module cgl_port
  import cgl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h2E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h2F,
  localparam int CW = 1 + IDX_W + TSEL_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      bus_rvalid,
  input  logic [NUM_TBL*IDX_W-1:0]  pix_addr,
  output logic [NUM_TBL*DATA_W-1:0] pix_rdata
);
  logic              sel_we, dat_wr, dat_rd;
  logic [TSEL_W-1:0] sel_tbl;
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_bulk, sel_ok;
  logic [TSEL_W-1:0] rd_tbl_q;
  logic              rd_ok_q;
  logic [DATA_W-1:0] tbl_rd [NUM_TBL];

  assign sel_we = bus_wr && (bus_addr == SEL_ADDR);
  assign dat_wr = bus_wr && (bus_addr == DAT_ADDR);
  assign dat_rd = bus_rd && !bus_wr && (bus_addr == DAT_ADDR);

  cgl_sel #(.IDX_W(IDX_W), .TSEL_W(TSEL_W), .NUM_TBL(NUM_TBL)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .sel_we   (sel_we),
    .sel_wdata(bus_wdata[CW-1:0]),
    .data_acc (dat_wr || dat_rd),
    .tbl      (sel_tbl),
    .idx      (sel_idx),
    .bulk     (sel_bulk),
    .tbl_ok   (sel_ok)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    localparam int TW = tbl_w(t);
    cgl_tbl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .W(TW), .SGN(tbl_sgn(t))) u_tbl (
      .clk   (clk),
      .we    (dat_wr && (32'(sel_tbl) == t)),
      .re    (dat_rd),
      .a_addr(sel_idx),
      .wdata (bus_wdata[TW-1:0]),
      .a_data(tbl_rd[t]),
      .b_addr(pix_addr[t*IDX_W +: IDX_W]),
      .b_data(pix_rdata[t*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      rd_ok_q    <= 1'b0;
      rd_tbl_q   <= '0;
    end else begin
      bus_rvalid <= dat_rd;
      if (dat_rd) begin
        rd_ok_q  <= sel_ok;
        rd_tbl_q <= sel_tbl;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TBL; t++)
      if (rd_ok_q && (32'(rd_tbl_q) == t)) bus_rdata = tbl_rd[t];
  end
endmodule

// File: rtl/cgl_port_chk.sv
module cgl_port_chk
  import cgl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h2F
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [TSEL_W-1:0] cur_tbl,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              cur_bulk
);
  logic rd_hit, acc_hit, rsv;
  assign rd_hit  = bus_rd && !bus_wr && (bus_addr == DAT_ADDR);
  assign acc_hit = (bus_rd || bus_wr) && (bus_addr == DAT_ADDR);
  assign rsv     = (32'(cur_tbl) >= NUM_TBL);

  // R4
  rvalid_set_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> bus_rvalid);

  // R4
  rvalid_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> !bus_rvalid);

  // R6
  bulk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_hit && cur_bulk && !rsv) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  // R5
  normal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_hit && !cur_bulk) |=> $stable(cur_idx));

  // R11
  rsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_hit && rsv) |=> $stable(cur_idx));

  // R11
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && rsv) |=> (bus_rvalid && bus_rdata == '0));
endmodule

bind cgl_port cgl_port_chk #(.DAT_ADDR(DAT_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .cur_tbl   (sel_tbl),
  .cur_idx   (sel_idx),
  .cur_bulk  (sel_bulk)
);

// File: tb/cgl_port_bench.sv
`timescale 1ns/1ps
module cgl_port_bench;
  localparam int NT = 6;
  localparam int IW = 6;
  localparam int DW = 16;
  localparam logic [7:0] A_SEL = 8'h2E;
  localparam logic [7:0] A_DAT = 8'h2F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_rvalid;
  logic [NT*IW-1:0] pix_addr = '0;
  logic [NT*DW-1:0] pix_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cgl_port u_cgl_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pix_addr(pix_addr), .pix_rdata(pix_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic sel(input int t, input int i, input bit b, input logic [5:0] junk = '0);
    wr(A_SEL, {junk, 3'(t), 6'(i), b});
  endtask

  task automatic pix(input int t, input int i, output logic [DW-1:0] d);
    @(negedge clk);
    pix_addr[t*IW +: IW] = 6'(i);
    @(negedge clk);
    d = pix_rdata[t*DW +: DW];
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check(bus_rvalid == 1'b0, "R1 rvalid after reset", {15'b0, bus_rvalid}, 16'h0);
    wr(A_DAT, 16'h0123);
    pix(0, 0, d);
    check(d == 16'h0123, "R1 default table0 slot0", d, 16'h0123);
  endtask

  task automatic t_select();
    logic [DW-1:0] d; logic v;
    sel(2, 17, 1'b0, 6'h3F);
    wr(A_DAT, 16'h0ABC);
    pix(2, 17, d);
    check(d == 16'h0ABC, "R2 R3 select decode and write", d, 16'h0ABC);
    rd(A_DAT, d, v);
    check(v == 1'b1, "R4 rvalid after read", {15'b0, v}, 16'h1);
    check(d == 16'h0ABC, "R4 read data", d, 16'h0ABC);
  endtask

  task automatic t_normal();
    logic [DW-1:0] d; logic v;
    sel(1, 6, 1'b0);
    wr(A_DAT, 16'h0111);
    sel(1, 5, 1'b0);
    wr(A_DAT, 16'h0AAA);
    wr(A_DAT, 16'h0BBB);
    rd(A_DAT, d, v);
    check(d == 16'h0BBB, "R5 same slot first read", d, 16'h0BBB);
    rd(A_DAT, d, v);
    check(d == 16'h0BBB, "R5 same slot second read", d, 16'h0BBB);
    pix(1, 6, d);
    check(d == 16'h0111, "R5 neighbour untouched", d, 16'h0111);
  endtask

  task automatic t_bulk();
    logic [DW-1:0] d; logic v;
    sel(3, 10, 1'b1);
    for (int i = 0; i < 10; i++) wr(A_DAT, 16'(16'h0100 + i));
    sel(3, 10, 1'b1);
    for (int i = 0; i < 10; i++) begin
      rd(A_DAT, d, v);
      check(d == 16'(16'h0100 + i) && v, "R6 bulk read stream", d, 16'(16'h0100 + i));
    end
    pix(3, 19, d);
    check(d == 16'h0109, "R6 bulk write last slot", d, 16'h0109);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] d;
    sel(4, 62, 1'b1);
    wr(A_DAT, 16'h00AA);
    wr(A_DAT, 16'h00BB);
    wr(A_DAT, 16'h00CC);
    pix(4, 63, d);
    check(d == 16'h00BB, "R7 slot 63", d, 16'h00BB);
    pix(4, 0, d);
    check(d == 16'h00CC, "R7 wrap to slot 0", d, 16'h00CC);
  endtask

  task automatic t_width();
    logic [DW-1:0] d; logic v;
    sel(0, 3, 1'b0);
    wr(A_DAT, 16'h2001);
    rd(A_DAT, d, v);
    check(d == 16'hE001, "R8 sign extend bit13", d, 16'hE001);
    wr(A_DAT, 16'hC123);
    rd(A_DAT, d, v);
    check(d == 16'h0123, "R8 truncate to 14 bits", d, 16'h0123);
    sel(1, 3, 1'b0);
    wr(A_DAT, 16'hFABC);
    rd(A_DAT, d, v);
    check(d == 16'h0ABC, "R9 zero extend 12 bits", d, 16'h0ABC);
    sel(2, 4, 1'b0);
    wr(A_DAT, 16'h8800);
    pix(2, 4, d);
    check(d == 16'h0800, "R9 pixel port zero extend", d, 16'h0800);
    sel(5, 3, 1'b0);
    wr(A_DAT, 16'h1FFF);
    rd(A_DAT, d, v);
    check(d == 16'hFFFF, "R10 sign extend bit12", d, 16'hFFFF);
    wr(A_DAT, 16'hEF00);
    rd(A_DAT, d, v);
    check(d == 16'h0F00, "R10 truncate to 13 bits", d, 16'h0F00);
    pix(5, 3, d);
    check(d == 16'h0F00, "R10 pixel port", d, 16'h0F00);
  endtask

  task automatic t_reserved();
    logic [DW-1:0] d; logic v;
    for (int t = 0; t < NT; t++) begin
      sel(t, 7, 1'b0);
      wr(A_DAT, 16'(16'h0040 + t));
    end
    sel(6, 7, 1'b1);
    wr(A_DAT, 16'h0555);
    rd(A_DAT, d, v);
    check(d == 16'h0 && v, "R11 reserved read zero", d, 16'h0);
    sel(7, 7, 1'b0);
    wr(A_DAT, 16'h0666);
    rd(A_DAT, d, v);
    check(d == 16'h0 && v, "R11 code7 read zero", d, 16'h0);
    for (int t = 0; t < NT; t++) begin
      pix(t, 7, d);
      check(d == 16'(16'h0040 + t), "R11 tables untouched", d, 16'(16'h0040 + t));
    end
  endtask

  task automatic t_other();
    logic [DW-1:0] d; logic v;
    sel(2, 1, 1'b0);
    wr(A_DAT, 16'h0321);
    wr(8'h2D, 16'h0F83);
    wr(8'h30, 16'h0777);
    rd(A_DAT, d, v);
    check(d == 16'h0321, "R12 other writes no effect", d, 16'h0321);
    rd(A_SEL, d, v);
    check(v == 1'b0, "R12 no rvalid on select read", {15'b0, v}, 16'h0);
    rd(8'h10, d, v);
    check(v == 1'b0, "R12 no rvalid on other read", {15'b0, v}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_normal();
    t_bulk();
    t_wrap();
    t_width();
    t_reserved();
    t_other();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, all requirements actual=hang expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule